// File: doc/BRIEF.md
# Low-Power Mode Transition Sequencer

This block tracks the operating mode of a small processor core and moves it between its running modes (full-speed, reduced-speed and slow watch-clock operation) and its two stopped modes, light sleep and watch. A one-cycle sleep request, qualified by five configuration bits, either parks the core in a plain stopped mode until a wake interrupt, or starts a timed direct hop. A direct hop passes through a stopped mode on its way to a different running mode.

A direct hop has two counted phases. The first counts a fixed number of periods of the clock the core ran on before the hop. The second counts a fixed number of periods of the clock it will run on afterwards. The block runs on one system clock. The oscillator and the watch clock reach it as one-cycle enable strobes, and each counter steps only on the strobe that belongs to its phase. The outputs are the current mode, a code for the active clock source, a CPU halt flag and a busy flag. All pins are plain control and status pins. There is no streaming interface and no back-pressure.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `mode` is 0, `clk_sel` is 0, and both `busy` and `cpu_halt` are low.
- R2: `mode` uses these codes: 0 full-speed, 1 reduced-speed, 2 light sleep, 3 watch, 4 slow watch-clock run. No other value appears. `cpu_halt` is high exactly when `mode` is 2 or 3.
- R3: In mode 0, a sleep request with `cfg_stby`, `cfg_watch`, `cfg_lowspd` and `cfg_direct` all high starts a direct hop. `mode` becomes 3 and `busy` rises. When the hop completes, `mode` becomes 4 and `busy` falls.
- R4: The hop of R3 counts PRE_CYC (3) oscillator strobes while `clk_sel` is 0. It then counts POST_CYC×SUB_DIV (14×8 = 112) watch strobes while `clk_sel` is 2. Watch strobes in the first phase and oscillator strobes in the second phase are not counted.
- R5: In mode 1, a sleep request with `cfg_stby`, `cfg_lowspd` and `cfg_medspd` low and `cfg_direct` high starts a direct hop through mode 2 to mode 0. It counts PRE_CYC×MED_DIV (24) oscillator strobes with `clk_sel` at 1, then POST_CYC (14) oscillator strobes with `clk_sel` at 0, for 38 in total.
- R6: A sleep request in a running mode (0, 1 or 4) that does not meet the R3 or R5 conditions enters a plain stopped mode, and `busy` stays low. With `cfg_stby` low the block enters mode 2 and `clk_sel` keeps its value. With `cfg_stby` high it enters mode 3 and `clk_sel` becomes 3.
- R7: `wake_irq` in a plain stopped mode moves the block to a running mode chosen by the configuration bits. If `cfg_lowspd` is high the block goes to mode 4 with `clk_sel` 2. Otherwise, if `cfg_medspd` is high, it goes to mode 1 with `clk_sel` 1. Otherwise it goes to mode 0 with `clk_sel` 0. In a running mode, `wake_irq` has no effect.
- R8: While `busy` is high, `sleep_req` and `wake_irq` have no effect on `mode`, `clk_sel` or the hop timing. A sleep request in a plain stopped mode is also ignored.
- R9: `clk_sel` codes: 0 oscillator, 1 oscillator divided by MED_DIV, 2 watch clock divided by SUB_DIV, 3 system clock stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | One-cycle sleep request pulse |
| wake_irq | input | 1 | Wake interrupt request |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| wclk_tick | input | 1 | One-cycle strobe per watch-clock period |
| cfg_stby | input | 1 | Standby select: picks the stopped mode |
| cfg_watch | input | 1 | Watch-clock timing select |
| cfg_lowspd | input | 1 | Selects slow watch-clock run as the target |
| cfg_medspd | input | 1 | Selects reduced-speed run as the target |
| cfg_direct | input | 1 | Enables direct hops |
| mode | output | 3 | Current operating mode code |
| clk_sel | output | 2 | Active clock source code |
| cpu_halt | output | 1 | CPU stopped |
| busy | output | 1 | Direct hop in progress |

## Verification
The assertions assume the configuration bits stay constant from a sleep request until the hop that request starts has completed. They also assume the strobe inputs are single-cycle enables sampled on the system clock edge, with no relation to `sleep_req`. The stimulus changes configuration bits only while the block is idle or in a plain stopped mode. It drives every input at the falling edge and holds it for one rising edge. It deliberately sends the wrong strobe during each phase, and sends sleep and wake pulses during a hop, so that the ignore rules are exercised.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    MODE_HS  = 3'd0,
    MODE_MS  = 3'd1,
    MODE_SLP = 3'd2,
    MODE_WCH = 3'd3,
    MODE_SUB = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    CLK_OSC  = 2'd0,
    CLK_MED  = 2'd1,
    CLK_WDIV = 2'd2,
    CLK_OFF  = 2'd3
  } clk_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_POST = 2'd2
  } phase_e;

  function automatic clk_e clk_of(mode_e m);
    case (m)
      MODE_HS:  return CLK_OSC;
      MODE_MS:  return CLK_MED;
      MODE_SUB: return CLK_WDIV;
      default:  return CLK_OFF;
    endcase
  endfunction

  function automatic logic is_running(mode_e m);
    return (m == MODE_HS) || (m == MODE_MS) || (m == MODE_SUB);
  endfunction
endpackage

// File: rtl/pms_decode.sv
module pms_decode
  import pms_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int T_PRE_HS = 3,
  parameter int T_PRE_MS = 24,
  parameter int T_POST_S = 112,
  parameter int T_POST_H = 14
) (
  input  mode_e            cur_mode,
  input  logic             stby,
  input  logic             watch,
  input  logic             lowspd,
  input  logic             medspd,
  input  logic             direct,
  output logic             go_direct,
  output mode_e            lp_mode,
  output mode_e            dst_mode,
  output logic [CNT_W-1:0] pre_tgt,
  output logic             pre_wclk,
  output logic [CNT_W-1:0] post_tgt,
  output logic             post_wclk,
  output mode_e            wake_dst
);
  logic hop_to_sub, hop_to_hs;

  assign hop_to_sub = (cur_mode == MODE_HS) && stby && watch && lowspd && direct;
  assign hop_to_hs  = (cur_mode == MODE_MS) && !stby && !lowspd && !medspd && direct;
  assign go_direct  = hop_to_sub || hop_to_hs;

  always_comb begin
    lp_mode   = stby ? MODE_WCH : MODE_SLP;
    dst_mode  = cur_mode;
    pre_tgt   = CNT_W'(T_PRE_HS);
    pre_wclk  = 1'b0;
    post_tgt  = CNT_W'(T_POST_H);
    post_wclk = 1'b0;
    if (hop_to_sub) begin
      lp_mode   = MODE_WCH;
      dst_mode  = MODE_SUB;
      pre_tgt   = CNT_W'(T_PRE_HS);
      post_tgt  = CNT_W'(T_POST_S);
      post_wclk = 1'b1;
    end else if (hop_to_hs) begin
      lp_mode  = MODE_SLP;
      dst_mode = MODE_HS;
      pre_tgt  = CNT_W'(T_PRE_MS);
      post_tgt = CNT_W'(T_POST_H);
    end
  end

  always_comb begin
    if (lowspd)      wake_dst = MODE_SUB;
    else if (medspd) wake_dst = MODE_MS;
    else             wake_dst = MODE_HS;
  end
endmodule

// File: rtl/pms_lat_cnt.sv
module pms_lat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = en && tick && (cnt_q == target - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!en || done)  cnt_q <= '0;
    else if (tick)         cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_below_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < target));

  assert_cnt_clear_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int PRE_CYC  = 3,
  parameter int POST_CYC = 14,
  parameter int MED_DIV  = 8,
  parameter int SUB_DIV  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_irq,
  input  logic       osc_tick,
  input  logic       wclk_tick,
  input  logic       cfg_stby,
  input  logic       cfg_watch,
  input  logic       cfg_lowspd,
  input  logic       cfg_medspd,
  input  logic       cfg_direct,
  output logic [2:0] mode,
  output logic [1:0] clk_sel,
  output logic       cpu_halt,
  output logic       busy
);
  localparam int T_PRE_HS = PRE_CYC;
  localparam int T_PRE_MS = PRE_CYC * MED_DIV;
  localparam int T_POST_S = POST_CYC * SUB_DIV;
  localparam int T_POST_H = POST_CYC;
  localparam int T_MAX_A  = (T_PRE_MS > T_POST_S) ? T_PRE_MS : T_POST_S;
  localparam int T_MAX    = (T_MAX_A > T_POST_H) ? T_MAX_A : T_POST_H;
  localparam int CNT_W    = $clog2(T_MAX + 1);

  mode_e            mode_q, dst_q;
  clk_e             clk_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] pre_tgt_q, post_tgt_q;
  logic             pre_wclk_q, post_wclk_q;

  logic             go_direct, pre_wclk_d, post_wclk_d;
  mode_e            lp_mode, dst_mode, wake_dst;
  logic [CNT_W-1:0] pre_tgt_d, post_tgt_d;

  pms_decode #(
    .CNT_W(CNT_W), .T_PRE_HS(T_PRE_HS), .T_PRE_MS(T_PRE_MS),
    .T_POST_S(T_POST_S), .T_POST_H(T_POST_H)
  ) u_decode (
    .cur_mode (mode_q),
    .stby     (cfg_stby),
    .watch    (cfg_watch),
    .lowspd   (cfg_lowspd),
    .medspd   (cfg_medspd),
    .direct   (cfg_direct),
    .go_direct(go_direct),
    .lp_mode  (lp_mode),
    .dst_mode (dst_mode),
    .pre_tgt  (pre_tgt_d),
    .pre_wclk (pre_wclk_d),
    .post_tgt (post_tgt_d),
    .post_wclk(post_wclk_d),
    .wake_dst (wake_dst)
  );

  logic             cnt_en, cnt_tick, cnt_done;
  logic [CNT_W-1:0] cnt_tgt;

  assign cnt_en   = (phase_q != PH_IDLE);
  assign cnt_tick = (phase_q == PH_PRE) ? (pre_wclk_q  ? wclk_tick : osc_tick)
                                        : (post_wclk_q ? wclk_tick : osc_tick);
  assign cnt_tgt  = (phase_q == PH_PRE) ? pre_tgt_q : post_tgt_q;

  pms_lat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .tick  (cnt_tick),
    .target(cnt_tgt),
    .done  (cnt_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_HS;
      dst_q       <= MODE_HS;
      clk_q       <= CLK_OSC;
      phase_q     <= PH_IDLE;
      pre_tgt_q   <= '0;
      post_tgt_q  <= '0;
      pre_wclk_q  <= 1'b0;
      post_wclk_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_PRE: if (cnt_done) begin
          phase_q <= PH_POST;
          clk_q   <= clk_of(dst_q);
        end
        PH_POST: if (cnt_done) begin
          phase_q <= PH_IDLE;
          mode_q  <= dst_q;
          clk_q   <= clk_of(dst_q);
        end
        default: begin
          if (is_running(mode_q) && sleep_req) begin
            mode_q <= lp_mode;
            if (go_direct) begin
              phase_q     <= PH_PRE;
              dst_q       <= dst_mode;
              pre_tgt_q   <= pre_tgt_d;
              post_tgt_q  <= post_tgt_d;
              pre_wclk_q  <= pre_wclk_d;
              post_wclk_q <= post_wclk_d;
            end else if (lp_mode == MODE_WCH) begin
              clk_q <= CLK_OFF;
            end
          end else if (!is_running(mode_q) && wake_irq) begin
            mode_q <= wake_dst;
            clk_q  <= clk_of(wake_dst);
          end
        end
      endcase
    end
  end

  assign mode     = mode_q;
  assign clk_sel  = clk_q;
  assign busy     = (phase_q != PH_IDLE);
  assign cpu_halt = (mode_q == MODE_SLP) || (mode_q == MODE_WCH);

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

  assert_busy_in_stop_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cpu_halt);

  assert_busy_ends_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mode == 3'd0 || mode == 3'd4));

  assert_req_ignored_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_done && (sleep_req || wake_irq)) |=> ($stable(mode) && busy));

  assert_plain_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sleep_req && !go_direct) |=> !busy);
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_irq = 1'b0, osc_tick = 1'b0, wclk_tick = 1'b0;
  logic cfg_stby = 1'b0, cfg_watch = 1'b0, cfg_lowspd = 1'b0;
  logic cfg_medspd = 1'b0, cfg_direct = 1'b0;
  logic [2:0] mode;
  logic [1:0] clk_sel;
  logic cpu_halt, busy;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pwr_mode_seq i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_irq(wake_irq),
    .osc_tick(osc_tick), .wclk_tick(wclk_tick), .cfg_stby(cfg_stby),
    .cfg_watch(cfg_watch), .cfg_lowspd(cfg_lowspd), .cfg_medspd(cfg_medspd),
    .cfg_direct(cfg_direct), .mode(mode), .clk_sel(clk_sel),
    .cpu_halt(cpu_halt), .busy(busy)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req, int m, int c, int h, int b);
    chk(req, "mode", int'(mode), m);
    chk(req, "clk_sel", int'(clk_sel), c);
    chk(req, "cpu_halt", int'(cpu_halt), h);
    chk(req, "busy", int'(busy), b);
  endtask

  task automatic step(logic s, logic w, logic o, logic t);
    @(negedge clk);
    sleep_req = s; wake_irq = w; osc_tick = o; wclk_tick = t;
    @(posedge clk);
    #1;
    sleep_req = 1'b0; wake_irq = 1'b0; osc_tick = 1'b0; wclk_tick = 1'b0;
  endtask

  task automatic set_cfg(logic sb, logic wt, logic ls, logic ms, logic dt);
    cfg_stby = sb; cfg_watch = wt; cfg_lowspd = ls; cfg_medspd = ms; cfg_direct = dt;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    chk_state("R1", 0, 0, 0, 0);
  endtask

  task automatic test_hop_to_sub();
    do_reset();
    set_cfg(1, 1, 1, 0, 1);
    step(1, 0, 0, 0);
    chk_state("R3", 3, 0, 1, 1);
    repeat (5) step(0, 0, 0, 1);
    chk_state("R4", 3, 0, 1, 1);
    repeat (2) step(0, 0, 1, 0);
    chk_state("R4", 3, 0, 1, 1);
    step(0, 0, 1, 0);
    chk_state("R4", 3, 2, 1, 1);
    repeat (4) step(0, 0, 1, 0);
    repeat (111) step(0, 0, 0, 1);
    chk_state("R4", 3, 2, 1, 1);
    step(1, 1, 0, 0);
    chk_state("R8", 3, 2, 1, 1);
    step(0, 0, 0, 1);
    chk_state("R3", 4, 2, 0, 0);
    step(0, 1, 1, 1);
    chk_state("R7", 4, 2, 0, 0);
  endtask

  task automatic test_hop_to_hs();
    do_reset();
    set_cfg(0, 0, 0, 1, 0);
    step(1, 0, 0, 0);
    chk_state("R6", 2, 0, 1, 0);
    step(0, 1, 0, 0);
    chk_state("R7", 1, 1, 0, 0);
    set_cfg(0, 0, 0, 0, 1);
    step(1, 0, 0, 0);
    chk_state("R5", 2, 1, 1, 1);
    repeat (10) step(0, 0, 0, 1);
    repeat (23) step(0, 0, 1, 0);
    chk_state("R5", 2, 1, 1, 1);
    step(0, 0, 1, 0);
    chk_state("R9", 2, 0, 1, 1);
    step(0, 1, 0, 0);
    chk_state("R8", 2, 0, 1, 1);
    repeat (13) step(0, 0, 1, 0);
    chk_state("R5", 2, 0, 1, 1);
    step(0, 0, 1, 0);
    chk_state("R5", 0, 0, 0, 0);
  endtask

  task automatic test_plain();
    do_reset();
    set_cfg(1, 0, 0, 0, 1);
    step(1, 0, 0, 0);
    chk_state("R6", 3, 3, 1, 0);
    step(1, 0, 1, 1);
    chk_state("R8", 3, 3, 1, 0);
    set_cfg(1, 0, 1, 0, 0);
    step(0, 1, 0, 0);
    chk_state("R7", 4, 2, 0, 0);
    set_cfg(0, 0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk_state("R6", 2, 2, 1, 0);
    repeat (20) step(0, 0, 1, 1);
    chk_state("R6", 2, 2, 1, 0);
    step(0, 1, 0, 0);
    chk_state("R7", 0, 0, 0, 0);
    set_cfg(0, 1, 1, 1, 1);
    step(1, 0, 0, 0);
    chk_state("R2", 2, 0, 1, 0);
  endtask

  initial begin
    fork
      begin
        test_hop_to_sub();
        test_hop_to_hs();
        test_plain();
      end
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule